// File: doc/BRIEF.md
# Four-Channel Edge-Triggered Timestamp Capture

This block takes a snapshot of a free-running counter when a chosen transition arrives on an external pin. Each of its four channels has its own two-flop synchroniser, its own edge detector and a 16-bit snapshot register. Software picks the transition that each channel reacts to, reads the stored timestamps back, and watches a sticky per-channel flag that says a new timestamp has arrived.

The last channel is shared. A mode bit in the control word decides whether it acts as a capture input. When the bit selects the compare role, that channel never takes a snapshot. The compare logic itself sits outside this block. The counter comes from outside too, on `count_i`.

Register port map, indexed by `addr_i`: 0 is the control word, 1 is the flag word, and 2, 3, 4 and 5 are the snapshot registers of channels 1 to 4. Any other address reads as zero. A read is requested with `rd_en_i`, and its data appears on `rdata_o` one clock later.

Top module: `tmr_capture_top`

## Requirements
- R1: After reset every snapshot register holds 0xFFFF, and the control word and the flag word read as zero.
- R2: A selected transition on a pin loads the value of `count_i` into that channel's register on the third rising clock edge after the pin changes (two synchroniser edges, then one load edge). Without a selected transition the register keeps its value.
- R3: Edge code 00 disables a channel: no transition loads its register or sets its flag.
- R4: Edge code 01 captures on a low-to-high transition only.
- R5: Edge code 10 captures on a high-to-low transition only.
- R6: Edge code 11 captures on both transitions.
- R7: In the control word, channel n takes bits [2n-1:2n-2] (channel 1 in bits 1:0, channel 4 in bits 7:6). Bit 8 selects the capture role of channel 4. Only bits 8:0 are stored, and the word reads back with bits 15:9 zero.
- R8: Channel 4 captures only while control bit 8 is 1. While bit 8 is 0 its register and flag stay untouched, whatever its edge code.
- R9: Each capture sets bit n-1 of the flag word (`cap_flag_o`). A flag stays set until a write to address 1 with a 1 in that bit position. If a capture and a clear fall in the same cycle, the capture wins.
- R10: A read of a snapshot register in the same cycle as a capture into it returns the value held before that capture.
- R11: Writes to the snapshot addresses (2 to 5) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_pin_i | input | 4 | Asynchronous capture pins, bit n-1 for channel n |
| count_i | input | 16 | Free-running timer count |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid one cycle after `rd_en_i` |
| cap_flag_o | output | 4 | Sticky capture flags |

## Verification
The assertions assume that `count_i` is a settled, synchronous value at each rising edge. They also assume that a pin holds each level for at least two clocks, so that every transition the synchroniser sees stays visible for one full detection cycle. The bench drives pins and counter only at falling edges. It keeps the counter constant while a transition travels through the synchroniser, and it waits several cycles between pin changes. Before it arms a new edge selection, it brings pins to their starting level with all channels disabled, so that leftover transitions cannot load a register.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_FLAG = 1;
   localparam int unsigned REG_CAP0 = 2;

endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tcap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o =  chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] &  prev_q;

endmodule

// File: rtl/tcap_chan.sv
module tcap_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rise_i,
   input  logic             fall_i,
   input  logic [1:0]       sel_i,
   input  logic             enable_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             hit_o,
   output logic [CNT_W-1:0] cap_o
);
   import tcap_pkg::*;

   logic             edge_ok;
   logic [CNT_W-1:0] cap_q;

   always_comb begin
      case (edge_sel_e'(sel_i))
         EDGE_RISE: edge_ok = rise_i;
         EDGE_FALL: edge_ok = fall_i;
         EDGE_BOTH: edge_ok = rise_i | fall_i;
         default:   edge_ok = 1'b0;
      endcase
   end

   assign hit_o = edge_ok & enable_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cap_q <= '1;
      else if (hit_o) cap_q <= cnt_i;
   end

   assign cap_o = cap_q;

endmodule

// File: rtl/tcap_regs.sv
module tcap_regs #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          wr_en_i,
   input  logic                          rd_en_i,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [DATA_W-1:0]             wdata_i,
   input  logic [NUM_CH-1:0]             hit_i,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  caps_i,
   output logic [NUM_CH-1:0][1:0]        sel_o,
   output logic                          in_mode_o,
   output logic [NUM_CH-1:0]             flag_o,
   output logic [DATA_W-1:0]             rdata_o
);
   import tcap_pkg::*;

   localparam int CTRL_W = 2 * NUM_CH + 1;

   logic [CTRL_W-1:0] ctrl_q;
   logic [NUM_CH-1:0] flag_q;
   logic [NUM_CH-1:0] clr_mask;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;
   logic              wr_ctrl;
   logic              wr_flag;
   logic              unused_wbits;

   assign wr_ctrl      = wr_en_i && (addr_i == ADDR_W'(REG_CTRL));
   assign wr_flag      = wr_en_i && (addr_i == ADDR_W'(REG_FLAG));
   assign clr_mask     = wr_flag ? wdata_i[NUM_CH-1:0] : '0;
   assign unused_wbits = ^wdata_i[DATA_W-1:CTRL_W];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= '0;
      else         flag_q <= (flag_q & ~clr_mask) | hit_i;
   end

   always_comb begin
      rd_mux = '0;
      if (addr_i == ADDR_W'(REG_CTRL)) begin
         rd_mux[CTRL_W-1:0] = ctrl_q;
      end else if (addr_i == ADDR_W'(REG_FLAG)) begin
         rd_mux[NUM_CH-1:0] = flag_q;
      end else begin
         for (int k = 0; k < NUM_CH; k++) begin
            if (addr_i == ADDR_W'(REG_CAP0 + k)) rd_mux[CNT_W-1:0] = caps_i[k];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_q <= '0;
      else if (rd_en_i) rdata_q <= rd_mux;
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
      assign sel_o[k] = ctrl_q[2*k+1 -: 2];
   end

   assign in_mode_o = ctrl_q[CTRL_W-1];
   assign flag_o    = flag_q;
   assign rdata_o   = rdata_q;

endmodule

// File: rtl/tmr_capture_top.sv
module tmr_capture_top #(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit SHARED_LAST = 1'b1,
   localparam int ADDR_W     = $clog2(NUM_CH + 2)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] cap_pin_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [NUM_CH-1:0] cap_flag_o
);

   if (NUM_CH < 1) begin : g_bad_nch
      $error("tmr_capture_top: NUM_CH must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("tmr_capture_top: CNT_W must lie in 1..DATA_W");
   end
   if (2 * NUM_CH + 1 >= DATA_W) begin : g_bad_ctrl
      $error("tmr_capture_top: control word does not fit DATA_W");
   end

   logic [NUM_CH-1:0]            hit;
   logic [NUM_CH-1:0]            rise;
   logic [NUM_CH-1:0]            fall;
   logic [NUM_CH-1:0]            ch_en;
   logic [NUM_CH-1:0][CNT_W-1:0] cap_val;
   logic [NUM_CH-1:0][1:0]       sel;
   logic                         in_mode;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      if (SHARED_LAST && k == NUM_CH - 1) begin : g_shared
         assign ch_en[k] = in_mode;
      end else begin : g_plain
         assign ch_en[k] = 1'b1;
      end

      tcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .pin_i  (cap_pin_i[k]),
         .rise_o (rise[k]),
         .fall_o (fall[k])
      );

      tcap_chan #(.CNT_W(CNT_W)) u_chan (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .rise_i   (rise[k]),
         .fall_i   (fall[k]),
         .sel_i    (sel[k]),
         .enable_i (ch_en[k]),
         .cnt_i    (count_i),
         .hit_o    (hit[k]),
         .cap_o    (cap_val[k])
      );
   end

   tcap_regs #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .rd_en_i   (rd_en_i),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .hit_i     (hit),
      .caps_i    (cap_val),
      .sel_o     (sel),
      .in_mode_o (in_mode),
      .flag_o    (cap_flag_o),
      .rdata_o   (rdata_o)
   );

endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 16,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 3,
   parameter bit SHARED_LAST = 1'b1
) (
   input logic                         clk_i,
   input logic                         rst_ni,
   input logic [CNT_W-1:0]             count_i,
   input logic                         wr_en_i,
   input logic                         rd_en_i,
   input logic [ADDR_W-1:0]            addr_i,
   input logic [DATA_W-1:0]            wdata_i,
   input logic [DATA_W-1:0]            rdata_o,
   input logic [NUM_CH-1:0]            flags,
   input logic [NUM_CH-1:0]            hit,
   input logic [NUM_CH-1:0][CNT_W-1:0] cap_val,
   input logic [NUM_CH-1:0][1:0]       sel,
   input logic                         in_mode
);
   import tcap_pkg::*;

   logic [NUM_CH-1:0] clr_now;
   assign clr_now = (wr_en_i && addr_i == ADDR_W'(REG_FLAG)) ? wdata_i[NUM_CH-1:0] : '0;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      // R2: a capture loads the counter value
      a_r2_capture_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
         hit[k] |=> cap_val[k] == $past(count_i));
      // R2: without a capture the register holds
      a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !hit[k] |=> $stable(cap_val[k]));
      // R9: every capture raises the flag
      a_r9_flag_on_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
         hit[k] |=> flags[k]);
      // R3: disabled channel never fires
      a_r3_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (sel[k] == 2'b00) |-> !hit[k]);
   end

   if (SHARED_LAST) begin : g_shared
      // R8: shared channel silent in compare role
      a_r8_compare_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !in_mode |-> !hit[NUM_CH-1]);
   end

   // R9: flags drop only through a write-one clear
   a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags != '0) |=> ((flags & ~clr_now) == '0) || 1'b1 ? 
         ((($past(flags) & ~$past(clr_now)) & ~flags) == '0) : 1'b1);

   // R10: read during capture returns the older value
   a_r10_read_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == ADDR_W'(REG_CAP0)) |=> rdata_o[CNT_W-1:0] == $past(cap_val[0]));

endmodule

bind tmr_capture_top tcap_chk #(
   .NUM_CH      (NUM_CH),
   .CNT_W       (CNT_W),
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .SHARED_LAST (SHARED_LAST)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .count_i (count_i),
   .wr_en_i (wr_en_i),
   .rd_en_i (rd_en_i),
   .addr_i  (addr_i),
   .wdata_i (wdata_i),
   .rdata_o (rdata_o),
   .flags   (cap_flag_o),
   .hit     (hit),
   .cap_val (cap_val),
   .sel     (sel),
   .in_mode (in_mode)
);

// File: tb/sim_tmr_capture_top.sv
`timescale 1ns/1ps
module sim_tmr_capture_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  pins = 4'b0000;
   logic [15:0] count = 16'h0000;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [15:0] wdata = 16'h0000;
   logic [15:0] rdata;
   logic [3:0]  flags;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] shadow [4];

   always #2 clk = ~clk;

   tmr_capture_top u0 (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .cap_pin_i  (pins),
      .count_i    (count),
      .wr_en_i    (wr_en),
      .rd_en_i    (rd_en),
      .addr_i     (addr),
      .wdata_i    (wdata),
      .rdata_o    (rdata),
      .cap_flag_o (flags)
   );

   // {ctrl[8:0], start pins, end pins, counter, expected capture mask}
   localparam int NV = 8;
   localparam logic [36:0] VEC [NV] = '{
      {9'h155, 4'b0000, 4'b1111, 16'h1234, 4'b1111},
      {9'h1AA, 4'b1111, 4'b0000, 16'h2345, 4'b1111},
      {9'h155, 4'b1111, 4'b0000, 16'h3456, 4'b0000},
      {9'h1FF, 4'b0101, 4'b1010, 16'h4567, 4'b1111},
      {9'h100, 4'b0000, 4'b1111, 16'h5678, 4'b0000},
      {9'h0FF, 4'b0000, 4'b1111, 16'h6789, 4'b0111},
      {9'h139, 4'b0000, 4'b1111, 16'h789A, 4'b0101},
      {9'h1AA, 4'b0000, 4'b1111, 16'h89AB, 4'b0000}
   };
   localparam string VTAG [NV] = '{"R4", "R5", "R4", "R6", "R3", "R8", "R7", "R5"};

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] d;
      for (int i = 0; i < 4; i++) shadow[i] = 16'hFFFF;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1: reset state
      rd(3'd0, d); check("R1 ctrl", d, 16'h0000);
      rd(3'd1, d); check("R1 flags", d, 16'h0000);
      for (int i = 0; i < 4; i++) begin
         rd(3'(2 + i), d); check("R1 capture", d, 16'hFFFF);
      end

      // R7: control read-back keeps bits 8:0 only
      wr(3'd0, 16'hFFFF);
      rd(3'd0, d); check("R7 ctrl width", d, 16'h01FF);

      // vector table walk
      for (int v = 0; v < NV; v++) begin
         wr(3'd0, 16'h0000);
         pins = VEC[v][27:24];
         idle(5);
         wr(3'd1, 16'h000F);
         wr(3'd0, {7'd0, VEC[v][36:28]});
         count = VEC[v][19:4];
         pins  = VEC[v][23:20];
         idle(5);
         rd(3'd1, d); check({VTAG[v], " R9 flags"}, d, {12'd0, VEC[v][3:0]});
         for (int i = 0; i < 4; i++) begin
            if (VEC[v][i]) shadow[i] = VEC[v][19:4];
            rd(3'(2 + i), d); check({VTAG[v], " R2 capture"}, d, shadow[i]);
         end
      end

      // R11: writes to snapshot registers are ignored
      wr(3'd2, 16'h0000);
      wr(3'd5, 16'h0000);
      rd(3'd2, d); check("R11 ch1 write", d, shadow[0]);
      rd(3'd5, d); check("R11 ch4 write", d, shadow[3]);

      // R9: write-one clear of a single flag, others stay
      wr(3'd0, 16'h00FF);
      wr(3'd1, 16'h000F);
      pins = 4'b0000; count = 16'h0A0A;
      idle(5);
      shadow[0] = 16'h0A0A; shadow[1] = 16'h0A0A; shadow[2] = 16'h0A0A;
      check("R9 flag after capture", {12'd0, flags}, 16'h0007);
      wr(3'd1, 16'h0001);
      rd(3'd1, d); check("R9 clear one", d, 16'h0006);
      idle(3);
      rd(3'd1, d); check("R9 sticky", d, 16'h0006);

      // R10 and R2 timing: read in the load cycle returns the old value
      wr(3'd0, 16'h0103);
      count = 16'hBEEF;
      @(negedge clk); pins[0] = 1'b1;
      @(negedge clk);
      @(negedge clk); rd_en = 1'b1; addr = 3'd2;
      @(negedge clk); rd_en = 1'b0; d = rdata;
      check("R10 read old", d, shadow[0]);
      rd(3'd2, d); check("R2 load latency", d, 16'hBEEF);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule